// File: doc/BRIEF.md
# Serial Control Register Port

This block is a slave on a synchronous three-wire control bus. The three wires are a serial clock, a serial data line and a vertical reset line. A bus master sends frames of sixteen bits. The first eight bits are an address byte and the last eight are a data byte, and each byte is sent least significant bit first. Frames addressed to 40h through 48h write nine control registers. These registers configure a horizontal resampling datapath: four line-position breakpoints, a line length, a base rate step, two curvature values, and a set of mode and control flags. A frame addressed to 49h is an identify read. During its data byte the port pulls the data line low, so the master reads 00h.

Every write lands in a shadow register first. The datapath sees only the active copies. On the rising edge of the vertical reset line, the shadow control register decides what happens:
- If its transfer flag is set, all nine shadow values are copied to the active set at once.
- If its init flag is set, a one-cycle datapath initialization pulse is issued.

As a result, settings never change in the middle of a field.

The serial lines are oversampled in the system clock domain through synchronizers, and rising serial-clock edges are detected there. If the serial clock stays idle for a set number of system cycles, the frame counter is cleared, so the next bit is taken as the first bit of an address byte.

Top module: `ser_ctrl_port`

## Requirements
- R1: A frame whose address byte is in 40h..48h stores its data byte in the matching shadow register, and the active outputs keep their values until a commit.
- R2: On a rising edge of `vrst_i`, if bit 4 (transfer) of the shadow register at 48h is 1, all nine shadow registers are copied to the active outputs. If that bit is 0, the active outputs do not change.
- R3: On a rising edge of `vrst_i`, if bit 3 (init) of the shadow register at 48h is 1, `dp_init_o` is high for exactly one clock cycle. If bit 3 is 0, `dp_init_o` stays low.
- R4: A frame is 16 bits, an address byte followed by a data byte, each sent LSB first. Each bit is taken from `ser_dat_i` at a rising edge of `ser_clk_i`.
- R5: In a frame whose address byte is 49h, `ser_dat_oe_o` is 1 and `ser_dat_o` is 0 from the end of the address byte to the end of the frame, so the master reads 00h. In the address byte of any frame, and in the data byte of any frame with another address, `ser_dat_oe_o` is 0.
- R6: Writes to any address outside 40h..48h, including 49h, change no register.
- R7: Field mapping of the active registers:
  - 40h → `outer_l_o`, 41h → `inner_l_o`, 42h → `inner_r_o`, 43h → `outer_r_o`, 44h → `line_len_o`, 45h → `rate_base_o`.
  - 46h: bits 5:0 → `curve_in_o`, bit 6 → `split_en_o`.
  - 47h: bits 5:0 → `curve_out_o`, bit 6 → `tst_a_o`, bit 7 → `notch_en_o`.
  - 48h: bit 0 → `zoom_o`, bit 1 → `wei_shift_o`, bit 2 → `weo_shift_o`, bit 5 → `hold_curve_o`, bit 6 → `tst_b_o`, bit 7 → `adapt_o`.
- R8: While `rst_ni` is low, all shadow and active registers clear to zero, the frame restarts, and `ser_dat_oe_o` and `dp_init_o` are 0.
- R9: If no rising serial-clock edge arrives for `IDLE_CYC` system cycles, the next bit is taken as bit 0 of an address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_clk_i | input | 1 | Serial bus clock |
| ser_dat_i | input | 1 | Serial bus data from the master |
| vrst_i | input | 1 | Vertical reset line; its rising edge commits settings |
| ser_dat_o | output | 1 | Serial data driven by the port (always low) |
| ser_dat_oe_o | output | 1 | Drive enable for `ser_dat_o` |
| outer_l_o | output | 8 | Active left outer breakpoint (40h) |
| inner_l_o | output | 8 | Active left inner breakpoint (41h) |
| inner_r_o | output | 8 | Active right inner breakpoint (42h) |
| outer_r_o | output | 8 | Active right outer breakpoint (43h) |
| line_len_o | output | 8 | Active line length code (44h) |
| rate_base_o | output | 8 | Active base rate step (45h) |
| curve_in_o | output | 6 | Active inner curvature (46h bits 5:0) |
| split_en_o | output | 1 | Odd/even output split enable (46h bit 6) |
| curve_out_o | output | 6 | Active outer curvature (47h bits 5:0) |
| tst_a_o | output | 1 | Test flag A (47h bit 6) |
| notch_en_o | output | 1 | Luma notch filter enable (47h bit 7) |
| zoom_o | output | 1 | Zoom/compress select for the centre (48h bit 0) |
| wei_shift_o | output | 1 | Input write-enable timing shift (48h bit 1) |
| weo_shift_o | output | 1 | Output write-enable timing shift (48h bit 2) |
| hold_curve_o | output | 1 | Keep curve from last active line (48h bit 5) |
| tst_b_o | output | 1 | Test flag B (48h bit 6) |
| adapt_o | output | 1 | Adapt flag (48h bit 7) |
| dp_init_o | output | 1 | One-cycle datapath init pulse |

## Verification
The assertions check four properties on every cycle:
- the shadow bank moves only on a write strobe;
- the active bank moves only on a vertical-reset edge;
- a write strobe and the init pulse never last two cycles;
- the read drive never switches on except at a serial-clock edge.

Other behaviours can only be shown by the bench's scenarios:
- That each address decodes to the right register and invalid addresses are ignored. The bench shows this with a sweep of all 256 addresses, each written with an arithmetic pattern, followed by a full readout after commit.
- That a commit without the transfer flag leaves the active set unchanged.
- That the identify read drives low during the whole data byte and nowhere else.
- That an idle gap realigns a broken frame.

// File: rtl/ser_ctrl_pkg.sv
package ser_ctrl_pkg;
  localparam int BYTE_W   = 8;
  localparam int NREG     = 9;
  localparam logic [BYTE_W-1:0] BASE_ADDR = 8'h40;
  localparam logic [BYTE_W-1:0] ID_ADDR   = 8'h49;
  // register indices (address - BASE_ADDR)
  localparam int IX_OUTER_L = 0;
  localparam int IX_INNER_L = 1;
  localparam int IX_INNER_R = 2;
  localparam int IX_OUTER_R = 3;
  localparam int IX_LINELEN = 4;
  localparam int IX_RATE    = 5;
  localparam int IX_CURVE_I = 6;
  localparam int IX_CURVE_O = 7;
  localparam int IX_CTL     = 8;
  // control register bits
  localparam int B_ZOOM  = 0;
  localparam int B_WEI   = 1;
  localparam int B_WEO   = 2;
  localparam int B_INIT  = 3;
  localparam int B_XFER  = 4;
  localparam int B_HOLD  = 5;
  localparam int B_TSTB  = 6;
  localparam int B_ADAPT = 7;
  localparam int CURVE_W = 6;
endpackage

// File: rtl/ser_ctrl_sync.sv
module ser_ctrl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain <= '0;
    else         chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/ser_ctrl_rx.sv
module ser_ctrl_rx #(
  parameter int DW       = 8,
  parameter int IDLE_CYC = 64,
  parameter logic [DW-1:0] RD_ADDR = 8'h49
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          sdat_i,
  output logic          wr_stb_o,
  output logic [DW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          rd_oe_o
);
  localparam int FRAME  = 2 * DW;
  localparam int CNT_W  = $clog2(FRAME);
  localparam int IDLE_W = $clog2(IDLE_CYC + 1);
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(FRAME - 1);
  localparam logic [CNT_W-1:0]  ADDR_BIT = CNT_W'(DW - 1);
  localparam logic [CNT_W-1:0]  DATA_BIT = CNT_W'(DW);
  localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(IDLE_CYC);

  logic              sclk_q;
  logic              rise;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DW-1:0]     shreg, addr_q, next_byte;
  logic [IDLE_W-1:0] idle_cnt;

  assign rise      = sclk_i & ~sclk_q;
  assign next_byte = {sdat_i, shreg[DW-1:1]};  // LSB first

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q    <= 1'b0;
      bit_cnt   <= '0;
      shreg     <= '0;
      addr_q    <= '0;
      idle_cnt  <= '0;
      wr_stb_o  <= 1'b0;
      wr_data_o <= '0;
    end else begin
      sclk_q <= sclk_i;
      if (rise) begin
        shreg    <= next_byte;
        idle_cnt <= '0;
        bit_cnt  <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
        if (bit_cnt == ADDR_BIT) addr_q <= next_byte;
        wr_stb_o  <= (bit_cnt == LAST_BIT);
        wr_data_o <= next_byte;
      end else begin
        wr_stb_o <= 1'b0;
        if (idle_cnt == IDLE_MAX) bit_cnt  <= '0;
        else                      idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

  assign wr_addr_o = addr_q;
  assign rd_oe_o   = (bit_cnt >= DATA_BIT) && (addr_q == RD_ADDR);

  // R4
  one_wr_per_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o);
  // R5
  oe_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_oe_o) |-> $past(rise));
endmodule

// File: rtl/ser_ctrl_regs.sv
module ser_ctrl_regs
  import ser_ctrl_pkg::*;
#(
  parameter int DW = BYTE_W,
  parameter int NR = NREG
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_stb_i,
  input  logic [DW-1:0]         wr_addr_i,
  input  logic [DW-1:0]         wr_data_i,
  input  logic                  vrst_i,
  output logic [NR-1:0][DW-1:0] active_o,
  output logic                  dp_init_o
);
  logic [NR-1:0][DW-1:0] shadow;
  logic [DW-1:0]         offset;
  logic                  hit;
  logic                  vrst_q, vrst_rise, commit;

  assign offset    = wr_addr_i - BASE_ADDR;
  assign hit       = wr_stb_i && (offset < DW'(NR));
  assign vrst_rise = vrst_i & ~vrst_q;
  assign commit    = vrst_rise & shadow[IX_CTL][B_XFER];

  for (genvar g = 0; g < NR; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow[g]   <= '0;
        active_o[g] <= '0;
      end else begin
        if (hit && offset == DW'(g)) shadow[g] <= wr_data_i;
        if (commit) active_o[g] <= shadow[g];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vrst_q    <= 1'b0;
      dp_init_o <= 1'b0;
    end else begin
      vrst_q    <= vrst_i;
      dp_init_o <= vrst_rise & shadow[IX_CTL][B_INIT];
    end
  end

  // R1
  shadow_only_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_i |=> $stable(shadow));
  // R2
  active_only_on_vrst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vrst_rise |=> $stable(active_o));
  // R3
  init_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dp_init_o |=> !dp_init_o);
endmodule

// File: rtl/ser_ctrl_port.sv
module ser_ctrl_port
  import ser_ctrl_pkg::*;
#(
  parameter int IDLE_CYC    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ser_clk_i,
  input  logic       ser_dat_i,
  input  logic       vrst_i,
  output logic       ser_dat_o,
  output logic       ser_dat_oe_o,
  output logic [7:0] outer_l_o,
  output logic [7:0] inner_l_o,
  output logic [7:0] inner_r_o,
  output logic [7:0] outer_r_o,
  output logic [7:0] line_len_o,
  output logic [7:0] rate_base_o,
  output logic [5:0] curve_in_o,
  output logic       split_en_o,
  output logic [5:0] curve_out_o,
  output logic       tst_a_o,
  output logic       notch_en_o,
  output logic       zoom_o,
  output logic       wei_shift_o,
  output logic       weo_shift_o,
  output logic       hold_curve_o,
  output logic       tst_b_o,
  output logic       adapt_o,
  output logic       dp_init_o
);
  logic sclk_s, sdat_s, vrst_s;
  logic                      wr_stb;
  logic [BYTE_W-1:0]         wr_addr, wr_data;
  logic [NREG-1:0][BYTE_W-1:0] act;
  logic                      ctl_unused;

  ser_ctrl_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ser_clk_i), .q_o(sclk_s));
  ser_ctrl_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ser_dat_i), .q_o(sdat_s));
  ser_ctrl_sync #(.STAGES(SYNC_STAGES)) u_sync_vrst (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(vrst_i), .q_o(vrst_s));

  ser_ctrl_rx #(.DW(BYTE_W), .IDLE_CYC(IDLE_CYC), .RD_ADDR(ID_ADDR)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_i   (sclk_s),
    .sdat_i   (sdat_s),
    .wr_stb_o (wr_stb),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data),
    .rd_oe_o  (ser_dat_oe_o)
  );

  ser_ctrl_regs #(.DW(BYTE_W), .NR(NREG)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_stb_i (wr_stb),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .vrst_i   (vrst_s),
    .active_o (act),
    .dp_init_o(dp_init_o)
  );

  // identify read: all bits pulled low
  assign ser_dat_o = 1'b0;

  assign outer_l_o    = act[IX_OUTER_L];
  assign inner_l_o    = act[IX_INNER_L];
  assign inner_r_o    = act[IX_INNER_R];
  assign outer_r_o    = act[IX_OUTER_R];
  assign line_len_o   = act[IX_LINELEN];
  assign rate_base_o  = act[IX_RATE];
  assign curve_in_o   = act[IX_CURVE_I][CURVE_W-1:0];
  assign split_en_o   = act[IX_CURVE_I][6];
  assign curve_out_o  = act[IX_CURVE_O][CURVE_W-1:0];
  assign tst_a_o      = act[IX_CURVE_O][6];
  assign notch_en_o   = act[IX_CURVE_O][7];
  assign zoom_o       = act[IX_CTL][B_ZOOM];
  assign wei_shift_o  = act[IX_CTL][B_WEI];
  assign weo_shift_o  = act[IX_CTL][B_WEO];
  assign hold_curve_o = act[IX_CTL][B_HOLD];
  assign tst_b_o      = act[IX_CTL][B_TSTB];
  assign adapt_o      = act[IX_CTL][B_ADAPT];
  // commit-time flags act from the shadow copy
  assign ctl_unused   = act[IX_CTL][B_INIT] ^ act[IX_CTL][B_XFER] ^ act[IX_CURVE_I][7];
endmodule

// File: tb/ser_ctrl_port_tb.sv
`timescale 1ns/1ps
module ser_ctrl_port_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, vrst = 1'b0;
  logic sdo, sdo_oe;
  logic [7:0] o_ol, o_il, o_ir, o_or, o_len, o_rate;
  logic [5:0] o_ci, o_co;
  logic o_split, o_tsta, o_notch, o_zoom, o_wei, o_weo, o_hold, o_tstb, o_adapt, o_init;
  int total = 0, bad = 0, init_pulses = 0;
  logic [7:0] exp_r [0:8];

  always #2.5 clk = ~clk;

  ser_ctrl_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat), .vrst_i(vrst),
    .ser_dat_o(sdo), .ser_dat_oe_o(sdo_oe),
    .outer_l_o(o_ol), .inner_l_o(o_il), .inner_r_o(o_ir), .outer_r_o(o_or),
    .line_len_o(o_len), .rate_base_o(o_rate), .curve_in_o(o_ci), .split_en_o(o_split),
    .curve_out_o(o_co), .tst_a_o(o_tsta), .notch_en_o(o_notch), .zoom_o(o_zoom),
    .wei_shift_o(o_wei), .weo_shift_o(o_weo), .hold_curve_o(o_hold), .tst_b_o(o_tstb),
    .adapt_o(o_adapt), .dp_init_o(o_init));

  always @(negedge clk) if (o_init) init_pulses++;

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] got_reg(input int i);
    case (i)
      0: return o_ol;  1: return o_il;  2: return o_ir;  3: return o_or;
      4: return o_len; 5: return o_rate;
      6: return {1'b0, o_split, o_ci};
      7: return {o_notch, o_tsta, o_co};
      default: return {o_adapt, o_tstb, o_hold, 2'b00, o_weo, o_wei, o_zoom};
    endcase
  endfunction

  task automatic check_all(input string req);
    for (int i = 0; i < 9; i++) begin
      logic [7:0] e;
      e = exp_r[i];
      if (i == 6) e[7] = 1'b0;
      if (i == 8) e[4:3] = 2'b00;
      chk($sformatf("%s reg%0d", req, i), int'(got_reg(i)), int'(e));
    end
  endtask

  // drive one bit; optionally check read drive before the rising edge
  task automatic send_bit(input logic b, input bit do_chk, input bit exp_oe);
    @(negedge clk); sdat = b;
    repeat (4) @(negedge clk);
    if (do_chk) begin
      chk("R5 oe", int'(sdo_oe), int'(exp_oe));
      if (exp_oe) chk("R5 data low", int'(sdo), 0);
    end
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] a, input logic [7:0] d, input bit do_chk);
    for (int i = 0; i < 8; i++) send_bit(a[i], do_chk, 1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i], do_chk, a == 8'h49);
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_vrst();
    @(negedge clk); vrst = 1'b1;
    repeat (4) @(negedge clk); vrst = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    for (int i = 0; i < 9; i++) exp_r[i] = 8'h00;
    // R8 reset state
    check_all("R8");
    chk("R8 oe", int'(sdo_oe), 0);
    chk("R8 init", int'(o_init), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R4 R6 R1: sweep all addresses, valid ones get pat(a)
    for (int a = 0; a < 256; a++)
      if (a != 8'h48) send_frame(8'(a), pat(a), 1'b0);
    send_frame(8'h48, 8'hB5, 1'b0);  // xfer=1, init=0
    check_all("R1 before commit");
    for (int i = 0; i < 8; i++) exp_r[i] = pat(8'h40 + i);
    exp_r[8] = 8'hB5;
    init_pulses = 0;
    pulse_vrst();
    check_all("R2 R6 R7 commit");
    chk("R3 no init", init_pulses, 0);

    // R2: commit without transfer flag leaves active set unchanged
    send_frame(8'h40, 8'h99, 1'b0);
    send_frame(8'h48, 8'h00, 1'b0);
    pulse_vrst();
    check_all("R2 no xfer");

    // R3: init + transfer
    send_frame(8'h48, 8'h18, 1'b0);
    init_pulses = 0;
    pulse_vrst();
    chk("R3 init pulse", init_pulses, 1);
    exp_r[0] = 8'h99; exp_r[8] = 8'h18;
    check_all("R2 R3 xfer");

    // R3: init alone pulses, no copy
    send_frame(8'h41, 8'h5A, 1'b0);
    send_frame(8'h48, 8'h08, 1'b0);
    init_pulses = 0;
    pulse_vrst();
    chk("R3 init only", init_pulses, 1);
    check_all("R2 init only");

    // R5: identify read and a non-identify frame
    send_frame(8'h49, 8'hFF, 1'b1);
    chk("R5 oe after read", int'(sdo_oe), 0);
    send_frame(8'h45, 8'hFF, 1'b1);

    // R9: broken frame realigned by idle gap
    for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0, 1'b0);
    repeat (100) @(negedge clk);
    send_frame(8'h42, 8'h3C, 1'b0);
    send_frame(8'h48, 8'h10, 1'b0);
    init_pulses = 0;
    pulse_vrst();
    exp_r[1] = 8'h5A; exp_r[2] = 8'h3C; exp_r[5] = 8'hFF; exp_r[8] = 8'h10;
    check_all("R9 realign");
    chk("R9 init", init_pulses, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule